// File: doc/BRIEF.md
# Shifted-Operand Recomputation Checker

This block wraps a small combinational ALU (add, subtract, AND, OR, XOR) and uses time redundancy to catch faults in it. Every request is computed twice on the same ALU.

The first pass feeds the operands unchanged and parks the result in a holding register. The second pass moves both operands up by `K` bit positions, runs them through the same ALU, and moves the result back down. A comparator then checks the two results against each other. Because a given physical ALU bit carries a different logical bit in each pass, a permanent stuck bit disturbs the two passes in different places. The check therefore catches permanent faults as well as transient ones.

On a mismatch the block raises its error flag and runs the whole operation once more. If the second attempt agrees with itself, the block answers with error low. If it disagrees again, the block answers with error high and returns the first-pass result. A fault-injection input lets a test force any single ALU output bit to a stuck value.

Top module: `shift_recompute_top`

## Requirements
- R1: The opcode selects the operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR. Results are taken modulo 2^W, and codes 5 to 7 give a result of zero.
- R2: With no mismatch, `done_o` goes high in the fourth cycle after the clock edge that samples `start_i` in the idle state. It stays high for exactly one cycle.
- R3: The first pass uses the plain operands and the second pass uses operands shifted left by K. On a fault-free ALU the two passes agree for every operation, so `error_o` is 0 at done and `result_o` holds the correct value.
- R4: A stuck value forced on any ALU output bit (0 to W+K-1) is flagged whenever it changes the outcome of either pass.
- R5: After a mismatch exactly one retry is run. `done_o` then goes high in the eighth cycle after the start edge, and no second retry follows.
- R6: `error_o` goes high in the cycle after the first failing comparison. If the retry comparison matches, `error_o` is 0 at done and the result is correct.
- R7: If the retry also mismatches, `done_o` comes with `error_o` = 1, and `result_o` carries the first-pass value of the retry.
- R8: `start_i` and the operand inputs are ignored while an operation is in progress. They neither change the answer nor cause an extra `done_o`.
- R9: After reset, `done_o`, `error_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled in idle |
| op_i | input | 3 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| fault_en_i | input | 1 | Enable the stuck-bit fault on the ALU output |
| fault_bit_i | input | $clog2(W+K) | ALU output bit to force |
| fault_val_i | input | 1 | Value forced on that bit |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | Operation result, valid with done |
| error_o | output | 1 | Mismatch flag |

## Verification
The bench sweeps a stuck fault of both polarities across every ALU output bit. This includes the carry and headroom bits above W, where a wrong shift or a truncated ALU would let faults slip through or raise false alarms.

A transient fault that is removed before the retry must produce an error pulse and then a clean answer. A design that never clears its flag, or that retries more than once, would show the wrong error value or the wrong latency.

Borrow and wrap-around vectors expose a second pass that loses carries or borrows. A stray `start_i` mid-operation would reveal a design that reloads its operands.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PASS1 = 3'd1,
        ST_PASS2 = 3'd2,
        ST_CMP   = 3'd3,
        ST_RETRY = 3'd4,
        ST_DONE  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/trc_shift.sv
module trc_shift #(
    parameter int WIN  = 16,
    parameter int WOUT = 20,
    parameter int SH   = 4,
    parameter bit LEFT = 1'b1
) (
    input  logic [WIN-1:0]  din,
    output logic [WOUT-1:0] dout
);
    generate
        if (LEFT) begin : g_up
            // widen, then move up; the headroom above WIN keeps the top bits
            logic [WOUT-1:0] wide;
            assign wide = WOUT'(din);
            assign dout = wide << SH;
        end else begin : g_down
            // take the WOUT bits that sit SH places up
            assign dout = din[SH +: WOUT];
        end
    endgenerate
endmodule

// File: rtl/trc_alu.sv
module trc_alu
    import trc_pkg::*;
#(
    parameter int AW  = 20,
    parameter int FBW = 5
) (
    input  logic [2:0]     op,
    input  logic [AW-1:0]  x,
    input  logic [AW-1:0]  y,
    input  logic           flt_en,
    input  logic [FBW-1:0] flt_bit,
    input  logic           flt_val,
    output logic [AW-1:0]  z
);
    logic [AW-1:0] raw;
    logic [AW-1:0] mask;

    always_comb begin
        unique case (op)
            OP_ADD:  raw = x + y;
            OP_SUB:  raw = x - y;
            OP_AND:  raw = x & y;
            OP_OR:   raw = x | y;
            OP_XOR:  raw = x ^ y;
            default: raw = '0;
        endcase
    end

    assign mask = AW'(1) << flt_bit;

    always_comb begin
        if (!flt_en)
            z = raw;
        else if (flt_val)
            z = raw | mask;
        else
            z = raw & ~mask;
    end
endmodule

// File: rtl/trc_cmp.sv
module trc_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         same
);
    logic [W-1:0] diff;
    assign diff = lhs ^ rhs;
    assign same = (diff == '0);
endmodule

// File: rtl/shift_recompute_top.sv
module shift_recompute_top
    import trc_pkg::*;
#(
    parameter int W = 16,
    parameter int K = 4,
    localparam int AW = W + K,
    localparam int FBW = $clog2(AW)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [2:0]     op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           fault_en_i,
    input  logic [FBW-1:0] fault_bit_i,
    input  logic           fault_val_i,
    output logic           done_o,
    output logic [W-1:0]   result_o,
    output logic           error_o
);
    typedef struct packed {
        seq_state_e   st;
        logic [2:0]   op;
        logic [W-1:0] opa;
        logic [W-1:0] opb;
        logic [W-1:0] hold;
        logic [W-1:0] shadow;
        logic         err;
        logic         retried;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st:      ST_IDLE,
        op:      3'd0,
        opa:     '0,
        opb:     '0,
        hold:    '0,
        shadow:  '0,
        err:     1'b0,
        retried: 1'b0
    };

    ctl_t q, d;

    logic [AW-1:0] ext_a, ext_b;
    logic [AW-1:0] up_a, up_b;
    logic [AW-1:0] alu_x, alu_y, alu_z;
    logic [W-1:0]  down_z;
    logic          same;
    logic          second_pass;

    assign ext_a = AW'(q.opa);
    assign ext_b = AW'(q.opb);

    trc_shift #(.WIN(W), .WOUT(AW), .SH(K), .LEFT(1'b1)) u_up_a (
        .din (q.opa),
        .dout(up_a)
    );

    trc_shift #(.WIN(W), .WOUT(AW), .SH(K), .LEFT(1'b1)) u_up_b (
        .din (q.opb),
        .dout(up_b)
    );

    assign second_pass = (q.st == ST_PASS2);
    assign alu_x = second_pass ? up_a : ext_a;
    assign alu_y = second_pass ? up_b : ext_b;

    trc_alu #(.AW(AW), .FBW(FBW)) u_alu (
        .op     (q.op),
        .x      (alu_x),
        .y      (alu_y),
        .flt_en (fault_en_i),
        .flt_bit(fault_bit_i),
        .flt_val(fault_val_i),
        .z      (alu_z)
    );

    trc_shift #(.WIN(AW), .WOUT(W), .SH(K), .LEFT(1'b0)) u_down (
        .din (alu_z),
        .dout(down_z)
    );

    trc_cmp #(.W(W)) u_cmp (
        .lhs (q.hold),
        .rhs (q.shadow),
        .same(same)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.op      = op_i;
                    d.opa     = a_i;
                    d.opb     = b_i;
                    d.err     = 1'b0;
                    d.retried = 1'b0;
                    d.st      = ST_PASS1;
                end
            end
            ST_PASS1: begin
                d.hold = alu_z[W-1:0];
                d.st   = ST_PASS2;
            end
            ST_PASS2: begin
                d.shadow = down_z;
                d.st     = ST_CMP;
            end
            ST_CMP: begin
                if (same) begin
                    d.err = 1'b0;
                    d.st  = ST_DONE;
                end else if (!q.retried) begin
                    d.err     = 1'b1;
                    d.retried = 1'b1;
                    d.st      = ST_RETRY;
                end else begin
                    d.err = 1'b1;
                    d.st  = ST_DONE;
                end
            end
            ST_RETRY: d.st = ST_PASS1;
            ST_DONE:  d.st = ST_IDLE;
            default:  d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= CTL_RESET;
        else
            q <= d;
    end

    assign done_o   = (q.st == ST_DONE);
    assign result_o = q.hold;
    assign error_o  = q.err;

endmodule

// File: rtl/trc_sva.sv
module trc_sva
    import trc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         done_o,
    input logic         error_o,
    input seq_state_e   st,
    input logic [W-1:0] hold,
    input logic [W-1:0] shadow,
    input logic [W-1:0] opa,
    input logic         retried
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2

    AST_CLEAN_DONE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !error_o) |-> (hold == shadow)); // R3

    AST_HOLD_KEPT_IN_PASS2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PASS2) |=> $stable(hold)); // R3

    AST_RETRY_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETRY) |-> ($past(st) == ST_CMP)); // R5

    AST_NO_SECOND_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMP && retried && hold != shadow) |=> (st == ST_DONE)); // R5

    AST_ERR_IN_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETRY) |-> error_o); // R6

    AST_ERR_DONE_AFTER_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && error_o) |-> retried); // R7

    AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {ST_PASS1, ST_PASS2, ST_CMP, ST_RETRY}) |=> $stable(opa)); // R8
endmodule

bind shift_recompute_top trc_sva #(.W(W)) u_sva (
    .clk    (clk),
    .rst_n  (rst_n),
    .done_o (done_o),
    .error_o(error_o),
    .st     (q.st),
    .hold   (q.hold),
    .shadow (q.shadow),
    .opa    (q.opa),
    .retried(q.retried)
);

// File: tb/tb_shift_recompute_top.sv
module tb_shift_recompute_top;
    localparam int W   = 16;
    localparam int K   = 4;
    localparam int AW  = W + K;
    localparam int FBW = $clog2(AW);
    localparam int NV  = 10;

    // {op, a, b, expected}
    localparam logic [50:0] VEC [0:NV-1] = '{
        {3'd0, 16'h1234, 16'h0FCD, 16'h2201},
        {3'd0, 16'hFFFF, 16'h0001, 16'h0000},
        {3'd1, 16'h0005, 16'h0007, 16'hFFFE},
        {3'd1, 16'h8000, 16'h0001, 16'h7FFF},
        {3'd2, 16'hF0F0, 16'h3C3C, 16'h3030},
        {3'd3, 16'hF0F0, 16'h0F0F, 16'hFFFF},
        {3'd4, 16'hAAAA, 16'hFFFF, 16'h5555},
        {3'd4, 16'h1234, 16'h1234, 16'h0000},
        {3'd0, 16'h8000, 16'h8000, 16'h0000},
        {3'd7, 16'h1234, 16'h5678, 16'h0000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [2:0]     op_i = '0;
    logic [W-1:0]   a_i = '0;
    logic [W-1:0]   b_i = '0;
    logic           fault_en_i = 1'b0;
    logic [FBW-1:0] fault_bit_i = '0;
    logic           fault_val_i = 1'b0;
    logic           done_o;
    logic [W-1:0]   result_o;
    logic           error_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shift_recompute_top #(.W(W), .K(K)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .fault_en_i(fault_en_i),
        .fault_bit_i(fault_bit_i), .fault_val_i(fault_val_i),
        .done_o(done_o), .result_o(result_o), .error_o(error_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ref_alu(input logic [2:0] op, input logic [AW-1:0] x,
                                              input logic [AW-1:0] y);
        case (op)
            3'd0: return x + y;
            3'd1: return x - y;
            3'd2: return x & y;
            3'd3: return x | y;
            3'd4: return x ^ y;
            default: return '0;
        endcase
    endfunction

    function automatic logic [AW-1:0] stuck(input logic [AW-1:0] v, input int bitpos, input bit val);
        logic [AW-1:0] r;
        r = v;
        r[bitpos] = val;
        return r;
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                          input int drop_at, input bit poke,
                          output int lat, output logic [W-1:0] res, output bit err,
                          output bit mid_err);
        @(negedge clk);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        mid_err = 1'b0;
        while (!done_o && lat < 20) begin
            if (lat == drop_at) fault_en_i = 1'b0;
            if (poke && lat == 1) begin
                start_i = 1'b1; a_i = ~a; b_i = ~b; op_i = 3'd4;
            end
            if (poke && lat == 2) start_i = 1'b0;
            if (lat == 4) mid_err = error_o;
            @(negedge clk);
            lat++;
        end
        res = result_o;
        err = error_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R2 done single cycle", done_o, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int lat;
        logic [W-1:0] res;
        bit err, mid;

        repeat (3) @(negedge clk);
        chk(done_o == 0, "R9 reset done", done_o, 0);
        chk(error_o == 0, "R9 reset error", error_o, 0);
        chk(result_o == 0, "R9 reset result", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 0 && error_o == 0, "R9 idle after reset", {done_o, error_o}, 0);

        // R1 / R2 / R3: fault-free table
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][50:48], VEC[i][47:32], VEC[i][31:16], -1, 1'b0, lat, res, err, mid);
            chk(res == VEC[i][15:0], $sformatf("R1 vector %0d result", i), res, VEC[i][15:0]);
            chk(lat == 4, $sformatf("R2 vector %0d latency", i), lat, 4);
            chk(err == 0, $sformatf("R3 vector %0d no error", i), err, 0);
        end

        // R8: stray start mid-operation ignored
        run_op(3'd0, 16'h0101, 16'h0202, -1, 1'b1, lat, res, err, mid);
        chk(res == 16'h0303, "R8 busy start ignored result", res, 16'h0303);
        chk(lat == 4, "R8 busy start latency", lat, 4);
        begin
            bit extra = 1'b0;
            for (int c = 0; c < 8; c++) begin
                @(negedge clk);
                if (done_o) extra = 1'b1;
            end
            chk(!extra, "R8 no extra done", extra, 0);
        end

        // R6: transient fault removed before retry
        fault_bit_i = FBW'(2); fault_val_i = 1'b1; fault_en_i = 1'b1;
        run_op(3'd0, 16'h0000, 16'h0000, 3, 1'b0, lat, res, err, mid);
        chk(mid == 1, "R6 error raised during retry", mid, 1);
        chk(lat == 8, "R5 retry latency", lat, 8);
        chk(err == 0, "R6 clean retry clears error", err, 0);
        chk(res == 16'h0000, "R6 clean retry result", res, 0);

        // R7: permanent fault on a low bit
        fault_bit_i = FBW'(2); fault_val_i = 1'b1; fault_en_i = 1'b1;
        run_op(3'd0, 16'h0000, 16'h0000, -1, 1'b0, lat, res, err, mid);
        chk(lat == 8, "R5 single retry only", lat, 8);
        chk(err == 1, "R7 double mismatch error", err, 1);
        chk(res == 16'h0004, "R7 first-pass result returned", res, 16'h0004);
        fault_en_i = 1'b0;

        // R4: stuck fault swept over every ALU output bit, both polarities
        for (int bp = 0; bp < AW; bp++) begin
            for (int v = 0; v < 2; v++) begin
                logic [AW-1:0] p1, p2w;
                logic [W-1:0] p2;
                bit mism;
                p1  = stuck(ref_alu(3'd0, AW'(16'h1357), AW'(16'h2468)), bp, v[0]);
                p2w = stuck(ref_alu(3'd0, AW'(16'h1357) << K, AW'(16'h2468) << K), bp, v[0]);
                p2  = p2w[K +: W];
                mism = (p1[W-1:0] != p2);
                fault_bit_i = FBW'(bp); fault_val_i = v[0]; fault_en_i = 1'b1;
                run_op(3'd0, 16'h1357, 16'h2468, -1, 1'b0, lat, res, err, mid);
                fault_en_i = 1'b0;
                chk(err == mism, $sformatf("R4 bit %0d val %0d error", bp, v), err, mism);
                chk(lat == (mism ? 8 : 4), $sformatf("R4 bit %0d val %0d latency", bp, v),
                    lat, mism ? 8 : 4);
                chk(res == p1[W-1:0], $sformatf("R4 bit %0d val %0d result", bp, v),
                    res, p1[W-1:0]);
            end
        end

        // R3: fault-free after injection, error cleared at next start
        run_op(3'd1, 16'h0000, 16'h0001, -1, 1'b0, lat, res, err, mid);
        chk(res == 16'hFFFF && err == 0, "R3 borrow after fault sweep", res, 16'hFFFF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule